// File: doc/BRIEF.md
# Three-Level Interrupt Aggregator

This block gathers a large set of interrupt source lines into one interrupt output and lets a host find the active source by walking a three-level status tree. Sources are grouped eight to a block and blocks eight to a master group. The host first reads a root byte naming the active master groups. It then reads the master status byte naming the active blocks. Finally it selects a block and reads that block's pending byte.

Each source has its own sensing configuration: edge or level, and separate masks for the rising (or high) and falling (or low) condition. The configuration is reached indirectly. The host writes a block number into a select register, then writes a config byte. That byte carries the source's bit index within the block, the sense fields, a clear command and a commit bit. Source lines are synchronised by two flops before detection.

The register port takes a one-cycle write strobe and a one-cycle read strobe, uses 16-bit addresses and 8-bit data, and returns read data registered one cycle after the read strobe.

Top module: `irq_tree_top`

## Requirements
- R1: After reset every source is masked in edge mode and every pending bit is zero. The interrupt output is low, and the root and block pending reads return zero. A line that toggles under the reset configuration sets nothing.
- R2: The register window starts at BASE (default 0x01BB). The offsets are: 0 root, 1 to 4 master groups 0 to 3, 5 block select (read/write, low bits hold the block number), 6 block pending, 7 config (write only, reads as zero), 8 raw line status. Reads of any other address return zero. Read data appears on rdata at the clock edge that samples rd_en and holds until the next read.
- R3: A config byte takes effect only when bit7 is 1. A write with bit7 at 0 changes no configuration and no pending bit.
- R4: In the config byte, bit0=1 selects level sensing (0 selects edge), bit1=1 masks falling/low, and bit2=1 masks rising/high. In edge mode an unmasked rising or falling transition of the synchronised line sets pending, and both edges may be enabled together.
- R5: In level mode, clearing bit2 detects a high line and clearing bit1 detects a low line.
- R6: Config bit3=1 clears the pending bit of the addressed source, and a clear wins over a set in the same cycle. In level mode, a pending bit cleared while its line stays active and unmasked is set again on the next clock.
- R7: A single config write with bit1, bit2 and bit3 all set masks the source and leaves its pending bit cleared.
- R8: The source addressed by a config write is block select × 8 + config bits[6:4]. A block pending read returns bit k = pending of source (block select × 8 + k).
- R9: A raw status read returns the synchronised line levels of the selected block, bit k for source block×8+k.
- R10: Master status bit i of group m is the OR of the pending bits of block m×8+i. Root bit m+1 is the OR of group m, and root bit 0 and bits above the last group read zero.
- R11: The interrupt output is a registered OR of all root group bits. It falls once every pending bit has been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lines | input | N_SRC | Asynchronous interrupt source lines |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | One-cycle read strobe |
| addr | input | 16 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq_out | output | 1 | Aggregated interrupt request |

## Verification
The bench builds the block with its default parameters: 256 sources, 32 blocks, four master groups and the window at 0x01BB. This full size puts the last group within reach. A source there shows up in root bit 4 and in the fourth master register, so the group-to-root bit offset is checked at its top end as well as at group 0. Directed scenarios drive sources in two different blocks and groups through each sense mode. They check the level re-set after a clear, the ignored uncommitted write, and reads of unused and write-only addresses.

// File: rtl/irq_tree_pkg.sv
package irq_tree_pkg;

  // register offsets inside the window (host walks them in this order)
  localparam logic [3:0] OFS_ROOT   = 4'd0;
  localparam logic [3:0] OFS_GRP0   = 4'd1;
  localparam logic [3:0] OFS_BSEL   = 4'd5;
  localparam logic [3:0] OFS_PEND   = 4'd6;
  localparam logic [3:0] OFS_CFG    = 4'd7;
  localparam logic [3:0] OFS_RAW    = 4'd8;
  localparam int unsigned WIN_SIZE  = 9;

  localparam int unsigned GRP_SLOTS = 4;   // fixed by the register window
  localparam int unsigned FAN       = 8;   // bits per status byte

  // low nibble of the config byte, MSB first
  typedef struct packed {
    logic clr;
    logic mask_hi;    // rising edge / high level
    logic mask_lo;    // falling edge / low level
    logic lvl_mode;
  } sense_cfg_t;

endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
  import irq_tree_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       line_in,
  input  logic       cfg_we,
  input  sense_cfg_t cfg_in,
  output logic       pending,
  output logic       level
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   lvl_mode_q;
  logic                   mask_hi_q;
  logic                   mask_lo_q;
  logic                   hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign level = sync_q[SYNC_STAGES-1];

  always_comb begin
    if (lvl_mode_q)
      hit = (level & ~mask_hi_q) | (~level & ~mask_lo_q);
    else
      hit = (level & ~prev_q & ~mask_hi_q) | (~level & prev_q & ~mask_lo_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_mode_q <= 1'b0;
      mask_hi_q  <= 1'b1;
      mask_lo_q  <= 1'b1;
      pending    <= 1'b0;
    end else begin
      if (cfg_we) begin
        lvl_mode_q <= cfg_in.lvl_mode;
        mask_hi_q  <= cfg_in.mask_hi;
        mask_lo_q  <= cfg_in.mask_lo;
      end
      if (cfg_we && cfg_in.clr)
        pending <= 1'b0;
      else if (hit)
        pending <= 1'b1;
    end
  end

  // R6: clear wins and leaves pending low on the following cycle
  a_r6_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_in.clr) |=> !pending);

  // R6: level source still active after a clear comes back next clock
  a_r6_level_reset: assert property (@(posedge clk) disable iff (rst)
    (lvl_mode_q && !mask_hi_q && level && !cfg_we) |=> pending);

  // R7: fully masked, untouched source never becomes pending
  a_r7_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (mask_hi_q && mask_lo_q && !pending && !cfg_we) |=> !pending);

endmodule

// File: rtl/irq_summary.sv
module irq_summary
  import irq_tree_pkg::*;
#(
  parameter int unsigned NUM_BLOCKS = 32,
  parameter int unsigned NUM_GRPS   = 4,
  parameter int unsigned PEND_W     = 256
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [PEND_W-1:0]        pend_all,
  output logic [NUM_GRPS*FAN-1:0]  blk_any,
  output logic [NUM_GRPS-1:0]      grp_any,
  output logic                     irq_out
);

  genvar b, g;
  generate
    for (b = 0; b < NUM_GRPS*FAN; b++) begin : g_blk
      if (b < NUM_BLOCKS) begin : g_real
        assign blk_any[b] = |pend_all[b*FAN +: FAN];
      end else begin : g_pad
        assign blk_any[b] = 1'b0;
      end
    end
    for (g = 0; g < NUM_GRPS; g++) begin : g_grp
      assign grp_any[g] = |blk_any[g*FAN +: FAN];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= |grp_any;
  end

  // R11: output rises only after some group was active
  a_r11_rise_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_out) |-> $past(|grp_any));

  // R11: output falls only after every group went quiet
  a_r11_fall_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_out) |-> !$past(|grp_any));

endmodule

// File: rtl/irq_regport.sv
module irq_regport
  import irq_tree_pkg::*;
#(
  parameter logic [15:0] BASE_ADDR  = 16'h01BB,
  parameter int unsigned NUM_GRPS   = 4,
  parameter int unsigned BLK_W      = 5,
  parameter int unsigned PEND_W     = 256
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [15:0]              addr,
  input  logic [7:0]               wdata,
  input  logic [PEND_W-1:0]        pend_all,
  input  logic [PEND_W-1:0]        lvl_all,
  input  logic [NUM_GRPS*FAN-1:0]  blk_any,
  input  logic [NUM_GRPS-1:0]      grp_any,
  output logic [7:0]               rdata,
  output logic                     cfg_strobe,
  output logic [BLK_W+2:0]         cfg_src,
  output sense_cfg_t               cfg_fields
);

  logic [15:0]      ofs;
  logic             in_win;
  logic [BLK_W-1:0] bsel_q;
  logic [7:0]       rd_mux;
  logic [7:0]       root_byte;

  assign ofs    = addr - BASE_ADDR;
  assign in_win = (addr >= BASE_ADDR) && (ofs < 16'(WIN_SIZE));

  always_ff @(posedge clk) begin
    if (rst)
      bsel_q <= '0;
    else if (wr_en && in_win && ofs[3:0] == OFS_BSEL)
      bsel_q <= wdata[BLK_W-1:0];
  end

  assign cfg_strobe = wr_en && in_win && (ofs[3:0] == OFS_CFG) && wdata[7];
  assign cfg_src    = {bsel_q, wdata[6:4]};
  assign cfg_fields = sense_cfg_t'(wdata[3:0]);

  always_comb begin
    root_byte = '0;
    for (int m = 0; m < NUM_GRPS; m++)
      root_byte[m+1] = grp_any[m];
  end

  always_comb begin
    rd_mux = '0;
    if (in_win) begin
      case (ofs[3:0])
        OFS_ROOT: rd_mux = root_byte;
        OFS_BSEL: rd_mux = 8'(bsel_q);
        OFS_PEND: rd_mux = pend_all[bsel_q*FAN +: FAN];
        OFS_RAW:  rd_mux = lvl_all[bsel_q*FAN +: FAN];
        default: begin
          for (int m = 0; m < NUM_GRPS; m++)
            if (ofs[3:0] == OFS_GRP0 + 4'(m))
              rd_mux = blk_any[m*FAN +: FAN];
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R2: addresses outside the window read back zero
  a_r2_outside_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !in_win) |=> (rdata == 8'h00));

  // R2: read data holds between reads
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  // R3: no config strobe for an uncommitted byte
  a_r3_commit_bit: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wdata[7]) |-> !cfg_strobe);

endmodule

// File: rtl/irq_tree_top.sv
module irq_tree_top
  import irq_tree_pkg::*;
#(
  parameter int unsigned N_SRC       = 256,
  parameter logic [15:0] BASE        = 16'h01BB,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_lines,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [15:0]      addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  output logic             irq_out
);

  localparam int unsigned NUM_BLOCKS = (N_SRC + FAN - 1) / FAN;
  localparam int unsigned NUM_GRPS   = (NUM_BLOCKS + FAN - 1) / FAN;
  localparam int unsigned BLK_W      = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1;
  localparam int unsigned PEND_W     = (1 << BLK_W) * FAN;

  initial begin
    if (NUM_GRPS > GRP_SLOTS) $error("too many sources for the register window");
  end

  logic [PEND_W-1:0]       pend_all;
  logic [PEND_W-1:0]       lvl_all;
  logic [NUM_GRPS*FAN-1:0] blk_any;
  logic [NUM_GRPS-1:0]     grp_any;
  logic                    cfg_strobe;
  logic [BLK_W+2:0]        cfg_src;
  sense_cfg_t              cfg_fields;

  genvar s;
  generate
    for (s = 0; s < PEND_W; s++) begin : g_src
      if (s < N_SRC) begin : g_cell
        irq_src_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
          .clk     (clk),
          .rst     (rst),
          .line_in (src_lines[s]),
          .cfg_we  (cfg_strobe && (cfg_src == (BLK_W+3)'(s))),
          .cfg_in  (cfg_fields),
          .pending (pend_all[s]),
          .level   (lvl_all[s])
        );
      end else begin : g_none
        assign pend_all[s] = 1'b0;
        assign lvl_all[s]  = 1'b0;
      end
    end
  endgenerate

  irq_summary #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .NUM_GRPS   (NUM_GRPS),
    .PEND_W     (PEND_W)
  ) u_summary (
    .clk      (clk),
    .rst      (rst),
    .pend_all (pend_all),
    .blk_any  (blk_any),
    .grp_any  (grp_any),
    .irq_out  (irq_out)
  );

  irq_regport #(
    .BASE_ADDR (BASE),
    .NUM_GRPS  (NUM_GRPS),
    .BLK_W     (BLK_W),
    .PEND_W    (PEND_W)
  ) u_regport (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata      (wdata),
    .pend_all   (pend_all),
    .lvl_all    (lvl_all),
    .blk_any    (blk_any),
    .grp_any    (grp_any),
    .rdata      (rdata),
    .cfg_strobe (cfg_strobe),
    .cfg_src    (cfg_src),
    .cfg_fields (cfg_fields)
  );

  // R1/R11: output low right after reset release
  a_r1_quiet_reset: assert property (@(posedge clk)
    $past(rst) |-> !irq_out);

endmodule

// File: tb/tb_irq_tree_top.sv
module tb_irq_tree_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] B = 16'h01BB;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [255:0] src_lines = '0;
  logic         wr_en = 1'b0;
  logic         rd_en = 1'b0;
  logic [15:0]  addr = '0;
  logic [7:0]   wdata = '0;
  logic [7:0]   rdata;
  logic         irq_out;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_tree_top dut (
    .clk(clk), .rst(rst), .src_lines(src_lines), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [15:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // config: lvl bit0, mask_lo bit1, mask_hi bit2, clr bit3, index [6:4], commit bit7
  task automatic cfg(int src, bit lvl, bit mlo, bit mhi, bit clr, bit commit = 1);
    wr(B + 16'd5, 8'(src / 8));
    wr(B + 16'd7, {commit, 3'(src % 8), clr, mhi, mlo, lvl});
  endtask

  task automatic rd_pend(int blk, output logic [7:0] d);
    wr(B + 16'd5, 8'(blk));
    rd(B + 16'd6, d);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 irq_out", 8'(irq_out), 8'h00);
    rd(B, d);                chk("R1 root", d, 8'h00);
    src_lines[5] = 1; idle(5); src_lines[5] = 0; idle(5);
    rd_pend(0, d);           chk("R1 masked after reset", d, 8'h00);
    chk("R1 irq_out stays low", 8'(irq_out), 8'h00);
  endtask

  task automatic t_edge();
    logic [7:0] d;
    cfg(10, 0, 1, 0, 1);              // rising only
    src_lines[10] = 1; idle(5);
    rd_pend(1, d);                    chk("R4 rising sets", d, 8'h04);
    chk("R11 irq_out", 8'(irq_out), 8'h01);
    rd(B, d);                         chk("R10 root grp0", d, 8'h02);
    rd(B + 16'd1, d);                 chk("R10 grp0 status", d, 8'h02);
    cfg(10, 0, 1, 0, 1);              // clear
    src_lines[10] = 0; idle(5);
    rd_pend(1, d);                    chk("R4 falling masked", d, 8'h00);
    chk("R11 irq_out falls", 8'(irq_out), 8'h00);
    cfg(10, 0, 0, 0, 1);              // both edges
    src_lines[10] = 1; idle(5);
    rd_pend(1, d);                    chk("R4 both rise", d, 8'h04);
    cfg(10, 0, 0, 0, 1);
    rd_pend(1, d);                    chk("R6 edge clear", d, 8'h00);
    src_lines[10] = 0; idle(5);
    rd_pend(1, d);                    chk("R4 both fall", d, 8'h04);
    cfg(10, 0, 1, 1, 1);
    rd_pend(1, d);                    chk("R7 mask ack edge", d, 8'h00);
  endtask

  task automatic t_level();
    logic [7:0] d;
    src_lines[200] = 1;
    cfg(200, 1, 1, 0, 1);             // active high
    idle(4);
    rd_pend(25, d);                   chk("R5 high level", d, 8'h01);
    rd(B, d);                         chk("R10 root grp3", d, 8'h10);
    rd(B + 16'd4, d);                 chk("R10 grp3 status", d, 8'h02);
    cfg(200, 1, 1, 0, 1);             // clear while active
    idle(2);
    rd_pend(25, d);                   chk("R6 level re-set", d, 8'h01);
    cfg(200, 1, 1, 1, 1);             // mask + ack
    idle(3);
    rd_pend(25, d);                   chk("R7 mask ack level", d, 8'h00);
    chk("R7 irq_out low", 8'(irq_out), 8'h00);
    src_lines[200] = 0;
    cfg(201, 1, 0, 1, 1);             // active low, line already low
    idle(4);
    rd_pend(25, d);                   chk("R5 low level / R8 index", d, 8'h02);
    cfg(201, 1, 1, 1, 1);
    rd(B, d);                         chk("R10 root clean", d, 8'h00);
  endtask

  task automatic t_commit();
    logic [7:0] d;
    src_lines[3] = 1; idle(4);
    cfg(3, 1, 1, 0, 0, 0);            // uncommitted
    idle(4);
    rd_pend(0, d);                    chk("R3 ignored", d, 8'h00);
    rd(B + 16'd8, d);                 chk("R9 raw level", d, 8'h08);
    cfg(3, 1, 1, 0, 0, 1);
    idle(4);
    rd_pend(0, d);                    chk("R3 committed", d, 8'h08);
    cfg(3, 1, 1, 1, 1);
    src_lines[3] = 0;
  endtask

  task automatic t_addr();
    logic [7:0] d;
    wr(B + 16'd5, 8'd19);
    rd(B + 16'd5, d);                 chk("R2 select readback", d, 8'd19);
    rd(B + 16'd7, d);                 chk("R2 config reads zero", d, 8'h00);
    rd(B + 16'd9, d);                 chk("R2 past window", d, 8'h00);
    rd(16'h0000, d);                  chk("R2 below window", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    idle(2);
    t_reset();
    t_edge();
    t_level();
    t_commit();
    t_addr();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vectors++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule